// File: doc/BRIEF.md
# Biphasic Bridge Pulse Sequencer

This block drives four bridge switches, A-high, A-low, B-high and B-low, with a train of biphasic pulses. Two phase timers count clock cycles at 16 ticks per microsecond. Each timer has four compare points. A matching point toggles one of four internal drive channels. When the first timer reaches its last point it stops and hands over to the second timer. When the second timer reaches its last point, the first timer starts again, unless that was the final pulse of the train.

Software loads a start-up idle time, seven interval lengths, a pulse count and a mode, then pulses a start strobe. The block accepts or refuses the strobe in the same cycle. The mode selects how channels map to switches and which levels the switches take when a train is loaded. After the last pulse the switches keep their levels until the next accepted start.

Top module: `bipulse_seq`

## Requirements
- R1: `start_ok` is high in any cycle where `start` is high, `busy` is low and `cfg_count` is nonzero. `start_rej` is high in any cycle where `start` is high and `start_ok` is low. An accepted start raises `busy` in the next cycle.
- R2: `busy` stays high from the cycle after an accepted start through the last cycle of the train, and low otherwise. While it is high, exactly one phase timer runs.
- R3: Phase A points are cumulative, in ticks: point0 = 16 x `cfg_idle_us`, and pointk = point(k-1) + 16 x interval(k-1) for k = 1..3. Interval i sits at bits [32i+31:32i] of `cfg_ivl_us`. The timer counts from 0, one step per cycle. Phase A runs from the cycle after an accepted start. A point that matches in a cycle changes the outputs in the next cycle.
- R4: Phase A toggles channel 0 at points 0 and 3, and channel 1 at points 1 and 2.
- R5: Phase B points are cumulative: point0 = 1 + 16 x interval3, and pointk = point(k-1) + 16 x interval(k+3) for k = 1..3. Phase B toggles channel 2 at points 0 and 3, and channel 3 at points 1 and 2.
- R6: A timer that reaches its point 3 clears and stops. Phase B then counts 0 in the next cycle. One pulse therefore lasts (A point3 + 1) + (B point3 + 1) cycles.
- R7: The pulse count drops by one at each phase B point 3. Phase A restarts only if the count remains nonzero. The train holds exactly `cfg_count` pulses.
- R8: Mode 0 maps channels 0..3 to A-high, B-low, B-high and A-low, with all channels loaded low.
- R9: Mode 1 maps channels 0..3 to B-high, B-low, A-high and A-low, with channel levels loaded as 1, 0, 1, 0. Mode values 2 and 3 behave as mode 0.
- R10: Each matching point toggles its channel once. Two points of one channel that match in the same cycle leave the channel unchanged.
- R11: After a train ends, the outputs hold their levels. A refused start changes neither the outputs nor the timing of a running train.
- R12: After reset, all four outputs and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idle_us | input | 32 | Idle time before the first toggle, in microseconds |
| cfg_ivl_us | input | 224 | Seven 32-bit intervals in microseconds; interval i at bits [32i+31:32i] |
| cfg_count | input | 32 | Number of pulses in the train |
| cfg_mode | input | 2 | Mapping mode: 1 = swapped, any other value = plain |
| start | input | 1 | Start strobe |
| start_ok | output | 1 | Start accepted in this cycle |
| start_rej | output | 1 | Start refused in this cycle |
| busy | output | 1 | A train is running |
| drv_ah | output | 1 | A-high switch drive |
| drv_al | output | 1 | A-low switch drive |
| drv_bh | output | 1 | B-high switch drive |
| drv_bl | output | 1 | B-low switch drive |

## Verification
Random trains vary the idle time, all seven intervals, the pulse count and all four mode values. The four switch levels and `busy` are compared against a reference model every cycle of each train and a few cycles after it. This exposes wrong point sums, a swapped channel pair, the wrong phase hand-over and the wrong pulse count. Directed trains use all-zero intervals, so that points coincide and toggles must cancel, and a single pulse in each mode, which checks the loaded levels. Start strobes issued mid-train, and a start with a zero count, must be refused without disturbing any output.

// File: rtl/bps_pkg.sv
package bps_pkg;
    localparam int TW     = 32;
    localparam int TPU    = 16;
    localparam int NIVL   = 7;
    localparam int NPT    = 4;
    localparam int NCH    = 4;
    localparam int CNT_W  = 32;
    localparam int MODE_W = 2;

    typedef logic [TW-1:0]           tick_t;
    typedef logic [NPT-1:0][TW-1:0]  ptset_t;
    typedef logic [NCH-1:0]          chan_t;

    typedef enum logic {
        MAP_PLAIN = 1'b0,
        MAP_SWAP  = 1'b1
    } map_e;

    function automatic tick_t us2tick(tick_t us);
        return us * tick_t'(TPU);
    endfunction

    function automatic map_e decode_mode(logic [MODE_W-1:0] m);
        return (m == MODE_W'(1)) ? MAP_SWAP : MAP_PLAIN;
    endfunction

    function automatic ptset_t build_pts(tick_t first, tick_t i0, tick_t i1, tick_t i2);
        ptset_t p;
        p[0] = first;
        p[1] = p[0] + us2tick(i0);
        p[2] = p[1] + us2tick(i1);
        p[3] = p[2] + us2tick(i2);
        return p;
    endfunction

    function automatic chan_t init_levels(map_e m);
        return (m == MAP_SWAP) ? chan_t'(4'b0101) : chan_t'(4'b0000);
    endfunction
endpackage

// File: rtl/bps_phase_timer.sv
module bps_phase_timer
    import bps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             kill,
    input  ptset_t           pts,
    output logic             run,
    output logic [NPT-1:0]   hit,
    output logic             last
);
    tick_t cnt;

    for (genvar k = 0; k < NPT; k++) begin : g_cmp
        assign hit[k] = run && (cnt == pts[k]);
    end
    assign last = hit[NPT-1];

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (go) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run) begin
            if (last) begin
                run <= 1'b0;
                cnt <= '0;
            end else begin
                cnt <= cnt + tick_t'(1);
            end
        end
    end

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= pts[NPT-1]));

    // R6
    stop_at_last_chk: assert property (@(posedge clk) disable iff (rst)
        (last && !go) |=> (!run && cnt == '0));
endmodule

// File: rtl/bps_train_ctl.sv
module bps_train_ctl
    import bps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             b_last,
    output logic             accept,
    output logic             refuse,
    output logic             active,
    output logic             restart_a,
    output logic             stop_all
);
    logic [CNT_W-1:0] rem;

    assign active    = (rem != '0);
    assign accept    = start && !active && (cfg_count != '0);
    assign refuse    = start && !accept;
    assign restart_a = b_last && (rem != CNT_W'(1));
    assign stop_all  = b_last && (rem == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (accept) begin
            rem <= cfg_count;
        end else if (b_last && active) begin
            rem <= rem - CNT_W'(1);
        end
    end

    // R1
    accept_load_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (active && rem == $past(cfg_count)));

    // R7
    rem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !b_last) |=> $stable(rem));
endmodule

// File: rtl/bps_drive_map.sv
module bps_drive_map
    import bps_pkg::*;
(
    input  map_e  map,
    input  chan_t ch,
    output logic  ah,
    output logic  al,
    output logic  bh,
    output logic  bl
);
    always_comb begin
        unique case (map)
            MAP_SWAP: begin
                bh = ch[0];
                bl = ch[1];
                ah = ch[2];
                al = ch[3];
            end
            default: begin
                ah = ch[0];
                bl = ch[1];
                bh = ch[2];
                al = ch[3];
            end
        endcase
    end
endmodule

// File: rtl/bipulse_seq.sv
module bipulse_seq
    import bps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [TW-1:0]        cfg_idle_us,
    input  logic [NIVL*TW-1:0]   cfg_ivl_us,
    input  logic [CNT_W-1:0]     cfg_count,
    input  logic [MODE_W-1:0]    cfg_mode,
    input  logic                 start,
    output logic                 start_ok,
    output logic                 start_rej,
    output logic                 busy,
    output logic                 drv_ah,
    output logic                 drv_al,
    output logic                 drv_bh,
    output logic                 drv_bl
);
    tick_t ivl [NIVL];
    for (genvar i = 0; i < NIVL; i++) begin : g_ivl
        assign ivl[i] = cfg_ivl_us[TW*i +: TW];
    end

    ptset_t pts_a, pts_b;
    map_e   map_r;
    chan_t  ch;

    logic accept, restart_a, stop_all;
    logic run_a, run_b, last_a, last_b;
    logic [NPT-1:0] hit_a, hit_b;

    bps_train_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_count (cfg_count),
        .b_last    (last_b),
        .accept    (accept),
        .refuse    (start_rej),
        .active    (busy),
        .restart_a (restart_a),
        .stop_all  (stop_all)
    );
    assign start_ok = accept;

    bps_phase_timer u_tmr_a (
        .clk  (clk),
        .rst  (rst),
        .go   (accept || restart_a),
        .kill (stop_all),
        .pts  (pts_a),
        .run  (run_a),
        .hit  (hit_a),
        .last (last_a)
    );

    bps_phase_timer u_tmr_b (
        .clk  (clk),
        .rst  (rst),
        .go   (last_a),
        .kill (stop_all),
        .pts  (pts_b),
        .run  (run_b),
        .hit  (hit_b),
        .last (last_b)
    );

    chan_t flips;
    assign flips = {hit_b[1] ^ hit_b[2], hit_b[0] ^ hit_b[3],
                    hit_a[1] ^ hit_a[2], hit_a[0] ^ hit_a[3]};

    always_ff @(posedge clk) begin
        if (rst) begin
            pts_a <= '0;
            pts_b <= '0;
            map_r <= MAP_PLAIN;
            ch    <= '0;
        end else if (accept) begin
            pts_a <= build_pts(us2tick(cfg_idle_us), ivl[0], ivl[1], ivl[2]);
            pts_b <= build_pts(tick_t'(1) + us2tick(ivl[3]), ivl[4], ivl[5], ivl[6]);
            map_r <= decode_mode(cfg_mode);
            ch    <= init_levels(decode_mode(cfg_mode));
        end else begin
            ch    <= ch ^ flips;
        end
    end

    bps_drive_map u_map (
        .map (map_r),
        .ch  (ch),
        .ah  (drv_ah),
        .al  (drv_al),
        .bh  (drv_bh),
        .bl  (drv_bl)
    );

    // R2
    one_phase_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_a ^ run_b));

    // R2
    idle_stop_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!run_a && !run_b));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable({drv_ah, drv_al, drv_bh, drv_bl}));

    // R1
    busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |-> start_rej);
endmodule

// File: tb/sim_bipulse_seq.sv
module sim_bipulse_seq;
    logic         clk = 1'b0;
    logic         rst;
    logic [31:0]  cfg_idle_us;
    logic [223:0] cfg_ivl_us;
    logic [31:0]  cfg_count;
    logic [1:0]   cfg_mode;
    logic         start;
    logic         start_ok, start_rej, busy;
    logic         drv_ah, drv_al, drv_bh, drv_bl;

    int n_chk  = 0;
    int n_fail = 0;

    int e_pa [4];
    int e_pb [4];
    int e_cnt;
    int e_mode;

    always #4 clk = ~clk;

    bipulse_seq u0 (
        .clk(clk), .rst(rst), .cfg_idle_us(cfg_idle_us), .cfg_ivl_us(cfg_ivl_us),
        .cfg_count(cfg_count), .cfg_mode(cfg_mode), .start(start),
        .start_ok(start_ok), .start_rej(start_rej), .busy(busy),
        .drv_ah(drv_ah), .drv_al(drv_al), .drv_bh(drv_bh), .drv_bl(drv_bl)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected {ah,al,bh,bl} in train cycle t (cycle 0 = first after accept)
    function automatic logic [3:0] exp_pins(int t);
        logic [3:0] ch;
        int per;
        per = e_pa[3] + e_pb[3] + 2;
        ch = (e_mode == 1) ? 4'b0101 : 4'b0000;
        for (int k = 0; k < e_cnt; k++) begin
            for (int i = 0; i < 4; i++) begin
                if (k * per + e_pa[i] < t)
                    ch[(i == 0 || i == 3) ? 0 : 1] ^= 1'b1;
                if (k * per + e_pa[3] + 1 + e_pb[i] < t)
                    ch[(i == 0 || i == 3) ? 2 : 3] ^= 1'b1;
            end
        end
        if (e_mode == 1) return {ch[2], ch[3], ch[0], ch[1]};
        return {ch[0], ch[3], ch[2], ch[1]};
    endfunction

    task automatic run_train(int idle, int iv[7], int cnt, int mode, int rej_at, string tag);
        int tend;
        e_pa[0] = idle * 16;
        for (int k = 1; k < 4; k++) e_pa[k] = e_pa[k-1] + iv[k-1] * 16;
        e_pb[0] = 1 + iv[3] * 16;
        for (int k = 1; k < 4; k++) e_pb[k] = e_pb[k-1] + iv[k+3] * 16;
        e_cnt  = cnt;
        e_mode = mode;
        tend   = cnt * (e_pa[3] + e_pb[3] + 2) - 1;

        @(negedge clk);
        cfg_idle_us = idle;
        for (int i = 0; i < 7; i++) cfg_ivl_us[32*i +: 32] = iv[i];
        cfg_count = cnt;
        cfg_mode  = mode[1:0];
        start     = 1'b1;
        #1;
        // R1: idle start with nonzero count is accepted
        check(start_ok && !start_rej, "R1 accept", {start_ok, start_rej}, 2'b10);

        for (int t = 0; t <= tend + 3; t++) begin
            @(negedge clk);
            start = 1'b0;
            // R3 R4 R5 R6 R7 R8 R9 R10 R11: per-cycle switch levels
            check({drv_ah, drv_al, drv_bh, drv_bl} == exp_pins(t), tag,
                  {drv_ah, drv_al, drv_bh, drv_bl}, exp_pins(t));
            // R2: busy window
            check(busy == (t <= tend), "R2 busy", busy, (t <= tend));
            if (t == rej_at && t <= tend) begin
                cfg_count = 32'd7;
                cfg_mode  = 2'd1;
                start     = 1'b1;
                #1;
                // R1 R11: start during a train is refused
                check(start_rej && !start_ok, "R1 refuse", {start_ok, start_rej}, 2'b01);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int iv[7];
        void'($urandom(20240611));
        rst = 1'b1; start = 1'b0; cfg_idle_us = '0; cfg_ivl_us = '0;
        cfg_count = '0; cfg_mode = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        check({drv_ah, drv_al, drv_bh, drv_bl, busy} == 5'b0, "R12 reset",
              {drv_ah, drv_al, drv_bh, drv_bl, busy}, 0);

        // R1: zero count refused while idle, nothing changes
        cfg_count = 0; cfg_mode = 2'd1; start = 1'b1;
        #1;
        check(start_rej && !start_ok, "R1 zero count", {start_ok, start_rej}, 2'b01);
        @(negedge clk);
        start = 1'b0;
        check({drv_ah, drv_al, drv_bh, drv_bl, busy} == 5'b0, "R11 zero count no effect",
              {drv_ah, drv_al, drv_bh, drv_bl, busy}, 0);

        // R10: all points coincide, toggles cancel
        iv = '{0, 0, 0, 0, 0, 0, 0};
        run_train(0, iv, 3, 0, -1, "R10 coincident");
        // R8: single pulse, plain mapping
        iv = '{1, 2, 1, 0, 1, 2, 1};
        run_train(1, iv, 1, 0, -1, "R8 mode0");
        // R9: single pulse, swapped mapping
        run_train(1, iv, 1, 1, -1, "R9 mode1");
        // R9: mode 3 behaves as plain, with a refused start mid-train
        run_train(2, iv, 2, 3, 40, "R9 mode3");
        // R11: held levels reach into next load
        iv = '{0, 1, 0, 2, 0, 1, 0};
        run_train(0, iv, 2, 1, 5, "R11 reload");

        // R3 R4 R5 R6 R7: random trains
        for (int n = 0; n < 20; n++) begin
            for (int i = 0; i < 7; i++) iv[i] = int'($urandom_range(0, 2));
            run_train(int'($urandom_range(0, 3)), iv, int'($urandom_range(1, 4)),
                      int'($urandom_range(0, 3)), int'($urandom_range(0, 200)),
                      "R3 R4 R5 R6 R7 random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule